// File: doc/BRIEF.md
# Larger-Immediate Decode Rewrite Unit

This unit sits in the decode stage of a five-stage in-order pipeline. It supports a family of wide-immediate ALU instructions that carry a 26-bit immediate and no register fields. Each such instruction operates on whichever register the most recent ALU instruction wrote. The unit keeps a small register holding that destination number. It is loaded from every regular ALU instruction that leaves decode.

When a wide-immediate instruction appears, the unit turns it into the matching ordinary immediate-form instruction. The remembered register is placed in both the source-1 and destination fields. The unit also supplies the 26-bit immediate sign-extended to 32 bits, through the same path that jump instructions use. A forwarding request tells the existing interlock and bypass network which stage holds the producer of the operand: MEM, WB, or none. That operand is routed only to the upper ALU input.

A second register keeps the last ALU result. It is loaded only when an ALU instruction is in writeback.

Top module: `li_decode_unit`

## Requirements
- R1: After reset, `last_dest_o` is 0 and `last_val_o` is 0, and no forwarding is requested. A wide-immediate instruction seen before any ALU instruction therefore names r0. An asynchronous reset in mid-run clears both registers at once.
- R2: A valid register-form ALU instruction leaving decode (opcode 0; `id_stall_i`=0, `id_squash_i`=0) loads bits [15:11] into `last_dest_o` on the next clock edge.
- R3: A valid immediate-form ALU instruction leaving decode (opcodes 0x08 to 0x0F) loads bits [20:16] into `last_dest_o` on the next clock edge.
- R4: `last_dest_o` does not change in these cases: the decode slot is stalled, the instruction is squashed, `id_valid_i` is 0, or the opcode is neither ALU form (for example load 0x23, jump 0x02, or a wide-immediate opcode).
- R5: Opcodes 0x38, 0x39, 0x3A and 0x3B are wide-immediate. They map to immediate opcodes 0x08, 0x09, 0x0A and 0x0B. `is_li_o` is 1 only for these opcodes with `id_valid_i`=1. Any other opcode, such as 0x3C, gives 0.
- R6: For a wide-immediate opcode, `instr_o` is built as follows. Bits [31:26] hold the mapped opcode. Bits [25:21] and [20:16] both hold `last_dest_o`. Bits [15:0] hold the low 16 immediate bits. Any other word passes through unchanged.
- R7: `imm_o` is bits [25:0] sign-extended for wide-immediate and jump opcodes (0x02, 0x03). For every other opcode it is bits [15:0] sign-extended.
- R8: Count decode cycles from the edge that loaded the last-destination register. On the first cycle after that edge, a valid wide-immediate instruction raises `hazard_req_o` with `fwd_sel_o`=1 (MEM). On the second cycle it raises `hazard_req_o` with `fwd_sel_o`=2 (WB). From the third cycle on, `hazard_req_o`=0 and `fwd_sel_o`=0. These cycles keep counting while decode is stalled. If the decode instruction is not a valid wide-immediate, `fwd_sel_o`=0 and `hazard_req_o`=0.
- R9: `last_val_o` takes the value of `wb_data_i` on a clock edge where `wb_alu_i`=1. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Decode slot holds an instruction |
| id_stall_i | input | 1 | Decode slot is held this cycle |
| id_squash_i | input | 1 | Decode instruction is being cancelled |
| id_instr_i | input | 32 | Instruction word in decode |
| wb_alu_i | input | 1 | An ALU instruction is in writeback |
| wb_data_i | input | 32 | Result of the writeback instruction |
| instr_o | output | 32 | Rewritten or passed-through instruction word |
| imm_o | output | 32 | Sign-extended immediate |
| is_li_o | output | 1 | Valid wide-immediate instruction in decode |
| hazard_req_o | output | 1 | Operand producer still in flight |
| fwd_sel_o | output | 2 | Upper ALU input source: 0 none, 1 MEM, 2 WB |
| last_dest_o | output | 5 | Remembered destination register number |
| last_val_o | output | 32 | Remembered last ALU result |

## Verification
The bench places a wide-immediate instruction directly behind its producer, one slot later, and well after it. A design that counted the distance wrongly would forward from the wrong stage, or would miss the forward entirely. Stalled, squashed and invalid ALU instructions, and loads, are fed in to confirm that the register number stays put. A design that sampled the destination too eagerly would aim the rewrite at a register that is never written. Negative 26-bit and 16-bit immediates and a jump word check the extender choice, since truncation or zero-extension would change the sign. A reset before any ALU instruction shows that the first rewrite names r0.

// File: rtl/li_pkg.sv
package li_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned OPC_W = 6;
  localparam int unsigned REG_W = 5;
  localparam int unsigned AGE_W = 2;

  typedef enum logic [1:0] {
    FWD_NONE = 2'd0,
    FWD_MEM  = 2'd1,
    FWD_WB   = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/li_detect.sv
module li_detect
  import li_pkg::*;
#(
  parameter int unsigned LI_BASE  = 56,
  parameter int unsigned LI_COUNT = 4,
  parameter int unsigned IMM_BASE = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opc_i,
  output logic             hit_o,
  output logic [OPC_W-1:0] imm_opc_o
);
  logic [LI_COUNT-1:0] hit_v;

  for (genvar k = 0; k < LI_COUNT; k++) begin : g_cmp
    assign hit_v[k] = (opc_i == OPC_W'(LI_BASE + k));
  end

  always_comb begin
    imm_opc_o = opc_i;
    for (int k = 0; k < LI_COUNT; k++) begin
      if (hit_v[k]) imm_opc_o = OPC_W'(IMM_BASE + k);
    end
  end

  assign hit_o = |hit_v;

  // R5
  one_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_v));
endmodule

// File: rtl/li_track.sv
module li_track
  import li_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic             wb_en_i,
  input  logic [XLEN-1:0]  wb_data_i,
  output logic [REG_W-1:0] ld_o,
  output logic [AGE_W-1:0] age_o,
  output logic [XLEN-1:0]  ldv_o
);
  localparam logic [AGE_W-1:0] AGE_DONE = AGE_W'(2);

  logic [REG_W-1:0] ld_q;
  logic [AGE_W-1:0] age_q;
  logic [XLEN-1:0]  ldv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q  <= '0;
      age_q <= AGE_DONE;
    end else if (upd_i) begin
      ld_q  <= rd_i;
      age_q <= '0;
    end else if (age_q != AGE_DONE) begin
      age_q <= age_q + 1'b1;
    end
  end

  // value register only clocks on ALU writeback
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ldv_q <= '0;
    else if (wb_en_i) ldv_q <= wb_data_i;
  end

  assign ld_o  = ld_q;
  assign age_o = age_q;
  assign ldv_o = ldv_q;

  // R8
  age_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q <= AGE_DONE);

  // R8
  age_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> age_q == '0);
endmodule

// File: rtl/li_rewrite.sv
module li_rewrite
  import li_pkg::*;
#(
  parameter int unsigned J_OPC_A = 2,
  parameter int unsigned J_OPC_B = 3
) (
  input  logic [XLEN-1:0]  instr_i,
  input  logic             li_i,
  input  logic [OPC_W-1:0] imm_opc_i,
  input  logic [REG_W-1:0] ld_i,
  output logic [XLEN-1:0]  instr_o,
  output logic [XLEN-1:0]  imm_o
);
  localparam int unsigned LONG_W  = XLEN - OPC_W;
  localparam int unsigned SHORT_W = 16;

  logic [OPC_W-1:0] opc;
  logic             long_imm;

  assign opc      = instr_i[XLEN-1 -: OPC_W];
  assign long_imm = li_i || (opc == OPC_W'(J_OPC_A)) || (opc == OPC_W'(J_OPC_B));

  always_comb begin
    if (li_i) instr_o = {imm_opc_i, ld_i, ld_i, instr_i[SHORT_W-1:0]};
    else      instr_o = instr_i;
  end

  always_comb begin
    if (long_imm) imm_o = {{(XLEN-LONG_W){instr_i[LONG_W-1]}}, instr_i[LONG_W-1:0]};
    else          imm_o = {{(XLEN-SHORT_W){instr_i[SHORT_W-1]}}, instr_i[SHORT_W-1:0]};
  end
endmodule

// File: rtl/li_decode_unit.sv
module li_decode_unit
  import li_pkg::*;
#(
  parameter int unsigned LI_BASE  = 56,
  parameter int unsigned LI_COUNT = 4,
  parameter int unsigned IMM_BASE = 8,
  parameter int unsigned IALU_LO  = 8,
  parameter int unsigned IALU_HI  = 15,
  parameter int unsigned J_OPC_A  = 2,
  parameter int unsigned J_OPC_B  = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        id_valid_i,
  input  logic        id_stall_i,
  input  logic        id_squash_i,
  input  logic [31:0] id_instr_i,
  input  logic        wb_alu_i,
  input  logic [31:0] wb_data_i,
  output logic [31:0] instr_o,
  output logic [31:0] imm_o,
  output logic        is_li_o,
  output logic        hazard_req_o,
  output logic [1:0]  fwd_sel_o,
  output logic [4:0]  last_dest_o,
  output logic [31:0] last_val_o
);
  logic [OPC_W-1:0] opc;
  logic             r_alu, i_alu, leave_id, upd;
  logic [REG_W-1:0] rd;
  logic             li_hit, li_v;
  logic [OPC_W-1:0] imm_opc;
  logic [REG_W-1:0] ld;
  logic [AGE_W-1:0] age;
  fwd_sel_e         fwd;

  assign opc      = id_instr_i[31 -: OPC_W];
  assign r_alu    = (opc == '0);
  assign i_alu    = (opc >= OPC_W'(IALU_LO)) && (opc <= OPC_W'(IALU_HI));
  assign leave_id = id_valid_i && !id_stall_i && !id_squash_i;
  assign upd      = leave_id && (r_alu || i_alu);
  assign rd       = r_alu ? id_instr_i[15:11] : id_instr_i[20:16];

  li_detect #(
    .LI_BASE (LI_BASE),
    .LI_COUNT(LI_COUNT),
    .IMM_BASE(IMM_BASE)
  ) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opc_i    (opc),
    .hit_o    (li_hit),
    .imm_opc_o(imm_opc)
  );

  li_track u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd),
    .rd_i     (rd),
    .wb_en_i  (wb_alu_i),
    .wb_data_i(wb_data_i),
    .ld_o     (ld),
    .age_o    (age),
    .ldv_o    (last_val_o)
  );

  li_rewrite #(
    .J_OPC_A(J_OPC_A),
    .J_OPC_B(J_OPC_B)
  ) u_rewrite (
    .instr_i  (id_instr_i),
    .li_i     (li_hit),
    .imm_opc_i(imm_opc),
    .ld_i     (ld),
    .instr_o  (instr_o),
    .imm_o    (imm_o)
  );

  assign li_v = li_hit && id_valid_i;

  // producer position relative to the rebuilt instruction entering EX
  always_comb begin
    fwd = FWD_NONE;
    if (li_v) begin
      case (age)
        AGE_W'(0): fwd = FWD_MEM;
        AGE_W'(1): fwd = FWD_WB;
        default:   fwd = FWD_NONE;
      endcase
    end
  end

  assign is_li_o      = li_v;
  assign fwd_sel_o    = fwd;
  assign hazard_req_o = (fwd != FWD_NONE);
  assign last_dest_o  = ld;

  // R2
  rtype_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leave_id && opc == '0) |=> last_dest_o == $past(id_instr_i[15:11]));

  // R4
  ld_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_valid_i || id_stall_i || id_squash_i) |=> $stable(last_dest_o));

  // R6
  li_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_li_o |-> (instr_o[25:21] == last_dest_o && instr_o[20:16] == last_dest_o));

  // R8
  hz_only_li_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hazard_req_o |-> is_li_o);

  // R9
  ldv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_alu_i |=> $stable(last_val_o));

  // R9
  ldv_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_alu_i |=> last_val_o == $past(wb_data_i));
endmodule

// File: tb/li_decode_unit_test.sv
module li_decode_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        id_valid_i = 1'b0, id_stall_i = 1'b0, id_squash_i = 1'b0;
  logic [31:0] id_instr_i = '0;
  logic        wb_alu_i = 1'b0;
  logic [31:0] wb_data_i = '0;
  logic [31:0] instr_o, imm_o, last_val_o;
  logic        is_li_o, hazard_req_o;
  logic [1:0]  fwd_sel_o;
  logic [4:0]  last_dest_o;

  int n_run = 0, n_fail = 0;
  logic [4:0] m_ld = '0;
  int         m_age = 2;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  li_decode_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .id_valid_i(id_valid_i), .id_stall_i(id_stall_i),
    .id_squash_i(id_squash_i), .id_instr_i(id_instr_i), .wb_alu_i(wb_alu_i),
    .wb_data_i(wb_data_i), .instr_o(instr_o), .imm_o(imm_o), .is_li_o(is_li_o),
    .hazard_req_o(hazard_req_o), .fwd_sel_o(fwd_sel_o), .last_dest_o(last_dest_o),
    .last_val_o(last_val_o)
  );

  // {valid, stall, squash, instr}
  localparam int NV = 15;
  localparam logic [34:0] VEC [NV] = '{
    {3'b100, 32'h0043_0820},  // add r1       R2
    {3'b100, 32'hE012_3456},  // wide add     R5 R6 R7 R8 (MEM)
    {3'b100, 32'h2045_FFFF},  // addi r5,-1   R3 R7
    {3'b100, 32'h8C07_0010},  // load         R4
    {3'b100, 32'hE7FF_FFFF},  // wide, neg    R7 R8 (WB)
    {3'b110, 32'h0043_4820},  // stalled add  R4
    {3'b101, 32'h0043_4820},  // squashed add R4
    {3'b000, 32'h0043_4820},  // invalid add  R4
    {3'b100, 32'hEA00_0001},  // wide, none   R8
    {3'b100, 32'h0A00_0010},  // jump         R7
    {3'b100, 32'h341F_8000},  // ori r31      R3
    {3'b110, 32'hEC00_0005},  // wide stalled R8
    {3'b100, 32'hEC00_0005},  // same, later  R8
    {3'b100, 32'hF000_0000},  // opc 0x3C     R5 R6
    {3'b000, 32'hE000_0001}   // wide invalid R5
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx26(input logic [31:0] w);
    return {{6{w[25]}}, w[25:0]};
  endfunction
  function automatic logic [31:0] sx16(input logic [31:0] w);
    return {{16{w[15]}}, w[15:0]};
  endfunction

  task automatic step(input logic v, input logic st, input logic sq, input logic [31:0] w);
    logic [5:0]  op;
    bit          li, alu;
    logic [31:0] e_instr, e_imm;
    logic [1:0]  e_fwd;
    @(negedge clk);
    id_valid_i = v; id_stall_i = st; id_squash_i = sq; id_instr_i = w;
    #1;
    op      = w[31:26];
    li      = (op >= 6'h38 && op <= 6'h3B);
    alu     = (op == 6'h00) || (op >= 6'h08 && op <= 6'h0F);
    e_instr = li ? {op - 6'h30, m_ld, m_ld, w[15:0]} : w;
    e_imm   = (li || op == 6'h02 || op == 6'h03) ? sx26(w) : sx16(w);
    e_fwd   = (v && li) ? (m_age == 0 ? 2'd1 : (m_age == 1 ? 2'd2 : 2'd0)) : 2'd0;
    chk(instr_o == e_instr, "R6 instr", instr_o, e_instr);
    chk(imm_o == e_imm, "R7 imm", imm_o, e_imm);
    chk(is_li_o == (v && li), "R5 is_li", 32'(is_li_o), 32'(v && li));
    chk(fwd_sel_o == e_fwd, "R8 fwd", 32'(fwd_sel_o), 32'(e_fwd));
    chk(hazard_req_o == (e_fwd != 0), "R8 hazard", 32'(hazard_req_o), 32'(e_fwd != 0));
    @(posedge clk); #1;
    if (v && !st && !sq && alu) begin
      m_ld  = (op == 6'h00) ? w[15:11] : w[20:16];
      m_age = 0;
    end else if (m_age != 2) m_age++;
    chk(last_dest_o == m_ld, "R2/R3/R4 last_dest", 32'(last_dest_o), 32'(m_ld));
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    // R1: reset state, first wide instruction targets r0
    chk(last_dest_o == 5'd0, "R1 ld reset", 32'(last_dest_o), 0);
    chk(last_val_o == 32'd0, "R1 ldv reset", last_val_o, 0);
    step(1'b1, 1'b0, 1'b0, 32'hE000_0007);
    chk(instr_o == 32'h2000_0007, "R1 r0 target", instr_o, 32'h2000_0007);

    // R9: value register load and hold
    @(negedge clk); wb_alu_i = 1'b0; wb_data_i = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    chk(last_val_o == 32'd0, "R9 hold", last_val_o, 0);
    @(negedge clk); wb_alu_i = 1'b1; wb_data_i = 32'hCAFE_0123;
    @(posedge clk); #1;
    chk(last_val_o == 32'hCAFE_0123, "R9 load", last_val_o, 32'hCAFE_0123);
    @(negedge clk); wb_alu_i = 1'b0; wb_data_i = 32'h1111_2222;
    @(posedge clk); #1;
    chk(last_val_o == 32'hCAFE_0123, "R9 hold after", last_val_o, 32'hCAFE_0123);
    if (m_age != 2) m_age = 2;  // idle cycles above let the distance counter expire

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:0]);
    end
    chk(last_dest_o == 5'd31, "R3 ori r31", 32'(last_dest_o), 31);

    // R1: asynchronous reset mid-run
    @(negedge clk); rst_ni = 1'b0; #1;
    chk(last_dest_o == 5'd0, "R1 async ld", 32'(last_dest_o), 0);
    chk(last_val_o == 32'd0, "R1 async ldv", last_val_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    m_ld = '0; m_age = 2;
    step(1'b1, 1'b0, 1'b0, 32'hE400_0009);
    chk(instr_o == 32'h2400_0009 && !hazard_req_o, "R1 post-reset wide", instr_o, 32'h2400_0009);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule